// File: doc/BRIEF.md
# Boot Address Walk Controller

This block lets a processor whose reset vector is fixed at address zero begin executing at a selectable 4K boundary in the upper half of the address space. No jump instruction or vector logic is involved. A reset edge can arm a pending flag. While the flag is armed, every byte returned to the processor is forced to zero, and the processor runs that zero as a no-op. Its program counter therefore climbs through memory until it reaches the selected region. The first read in that region drops the flag, and from then on every memory location is visible as normal.

The same region decode drives the chip select of a 1K on-board ROM placed at the chosen base. It also drives the enable of the external data-in receivers. A strap input decides whether those receivers are switched off during ROM reads. When no ROM is fitted, the strap keeps the receivers on, so system memory at the jump address stays readable. The base is picked with a one-hot selector. Any other selector pattern means no region.

Top module: `boot_walk_ctrl`

## Requirements
- R1: On each clock where `cpu_reset` is high and was low on the previous clock, the pending flag loads the inverse of `jump_en_n`: armed if it is low, cleared if it is high. This load takes priority over clearing by the ROM region.
- R2: While the flag is armed and `rom_cs` is low, `cpu_din` is 0x00 and `rcv_en` is 0, whatever `bus_din` and `addr` hold.
- R3: A cycle with `rom_cs` high while the flag is armed already delivers the normal read data. The flag is cleared at the next clock edge, and later reads at any address return `bus_din`.
- R4: Selector bit b of `base_sel` (b from 7 down to 0) places the region at block 15-b of 4K. Bit 7 gives 0x8000, bit 4 gives 0xB000 and bit 0 gives 0xF000.
- R5: When `base_sel` is all zero or has more than one bit set, `rom_cs` stays low for every address.
- R6: `rom_cs` covers exactly the 1K bytes from the base up to base+0x3FF. It is low at base+0x400 and at base-1.
- R7: `rom_cs` is high only while `mem_rd` is high. An I/O or idle cycle at a matching address neither selects the ROM nor clears the flag.
- R8: When `rom_cs` is high and `blank_on_rom` is 1, `rcv_en` is 0 and `cpu_din` equals `rom_dout`. When `blank_on_rom` is 0, `rcv_en` is 1 and `cpu_din` equals `bus_din`.
- R9: Without a region hit, an armed flag stays armed for any number of cycles, for example with the processor stopped at address 0x0000.
- R10: `por_n` low clears the flag at once, without a clock, and forgets the last reset level. If `cpu_reset` is held high through power-on, the first clock after `por_n` rises counts as a reset edge.
- R11: With the flag clear and `rom_cs` low, `cpu_din` equals `bus_din` and `rcv_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| cpu_reset | input | 1 | Processor reset level, active high |
| jump_en_n | input | 1 | Boot walk enable, active low |
| base_sel | input | 8 | One-hot region base selector |
| blank_on_rom | input | 1 | Turn receivers off during ROM reads (ROM fitted) |
| addr | input | 16 | Processor address bus |
| mem_rd | input | 1 | Memory read request in progress |
| bus_din | input | 8 | Data from the external receivers |
| rom_dout | input | 8 | Data from the on-board ROM |
| cpu_din | output | 8 | Data presented to the processor |
| rcv_en | output | 1 | Enable for the external data-in receivers |
| rom_cs | output | 1 | On-board ROM chip select |

## Verification
The bench probes the window edges at base-1, base+0x3FF and base+0x400. A decoder with the wrong mask or an off-by-one block number would select the ROM outside its 1K or miss the base. It checks that the region hit itself returns real data. A design that clears the flag only from the registered state would hand the processor one more zero at the boot address and skip its first opcode. It also sends I/O cycles to the base address while armed and applies two-hot and empty selectors. Power-on with reset held high must arm the flag without a separate reset pulse.

// File: rtl/bw_pkg.sv
package bw_pkg;

  typedef enum logic [1:0] {
    SRC_BUS  = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_ZERO = 2'd2
  } din_src_e;

  // Chooses where the processor read data comes from.
  function automatic din_src_e pick_src(input logic pending,
                                        input logic rom_hit,
                                        input logic blank_rom);
    din_src_e s;
    if (rom_hit && blank_rom)  s = SRC_ROM;
    else if (rom_hit)          s = SRC_BUS;
    else if (pending)          s = SRC_ZERO;
    else                       s = SRC_BUS;
    return s;
  endfunction

endpackage

// File: rtl/bw_base_decode.sv
module bw_base_decode #(
  parameter int ADDR_W   = 16,
  parameter int BLOCK_AW = 12
) (
  input  logic [(2**(ADDR_W-BLOCK_AW-1))-1:0] base_sel,
  output logic                                base_ok,
  output logic [ADDR_W-BLOCK_AW-1:0]          base_blk
);
  localparam int BLK_W = ADDR_W - BLOCK_AW;
  localparam int SEL_N = 2 ** (BLK_W - 1);
  localparam int TOP   = (2 ** BLK_W) - 1;

  function automatic int ones(input logic [SEL_N-1:0] v);
    int n = 0;
    for (int i = 0; i < SEL_N; i++) n += int'(v[i]);
    return n;
  endfunction

  logic [BLK_W-1:0] cand [SEL_N];

  genvar b;
  generate
    for (b = 0; b < SEL_N; b++) begin : g_cand
      localparam logic [BLK_W-1:0] BLK_B = BLK_W'(TOP - b);
      assign cand[b] = base_sel[b] ? BLK_B : '0;
    end
  endgenerate

  always_comb begin
    base_blk = '0;
    for (int i = 0; i < SEL_N; i++) base_blk = base_blk | cand[i];
  end

  assign base_ok = (ones(base_sel) == 1);

endmodule

// File: rtl/bw_region_match.sv
module bw_region_match #(
  parameter int ADDR_W   = 16,
  parameter int BLOCK_AW = 12,
  parameter int ROM_AW   = 10
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       mem_rd,
  input  logic                       base_ok,
  input  logic [ADDR_W-BLOCK_AW-1:0] base_blk,
  output logic                       rom_cs
);
  localparam int BLK_W = ADDR_W - BLOCK_AW;
  localparam int SUB_W = BLOCK_AW - ROM_AW;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [BLK_W-1:0]  blk);
    return (a[ADDR_W-1:BLOCK_AW] == blk) &&
           (a[BLOCK_AW-1:ROM_AW] == SUB_W'(0));
  endfunction

  logic hit_addr;
  assign hit_addr = in_window(addr, base_blk);
  assign rom_cs   = mem_rd && base_ok && hit_addr;

endmodule

// File: rtl/bw_pending_flag.sv
module bw_pending_flag (
  input  logic clk,
  input  logic por_n,
  input  logic cpu_reset,
  input  logic jump_en_n,
  input  logic rom_cs,
  output logic pending_q,
  output logic reset_rise
);
  logic reset_q;

  assign reset_rise = cpu_reset && !reset_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      reset_q   <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      reset_q <= cpu_reset;
      if (reset_rise)  pending_q <= !jump_en_n;
      else if (rom_cs) pending_q <= 1'b0;
    end
  end

  AST_LOAD_ON_RESET: assert property (@(posedge clk) disable iff (!por_n)
    reset_rise |=> (pending_q == !$past(jump_en_n)));                 // R1
  AST_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!por_n)
    (!reset_rise && rom_cs) |=> !pending_q);                          // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (!reset_rise && !rom_cs) |=> (pending_q == $past(pending_q)));    // R9

endmodule

// File: rtl/boot_walk_ctrl.sv
module boot_walk_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int BLOCK_AW = 12,
  parameter int ROM_AW   = 10
) (
  input  logic                                clk,
  input  logic                                por_n,
  input  logic                                cpu_reset,
  input  logic                                jump_en_n,
  input  logic [(2**(ADDR_W-BLOCK_AW-1))-1:0] base_sel,
  input  logic                                blank_on_rom,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                mem_rd,
  input  logic [DATA_W-1:0]                   bus_din,
  input  logic [DATA_W-1:0]                   rom_dout,
  output logic [DATA_W-1:0]                   cpu_din,
  output logic                                rcv_en,
  output logic                                rom_cs
);
  import bw_pkg::*;

  localparam int BLK_W = ADDR_W - BLOCK_AW;

  logic             base_ok;
  logic [BLK_W-1:0] base_blk;
  logic             pending_q;
  logic             reset_rise;
  din_src_e         src;

  bw_base_decode #(.ADDR_W(ADDR_W), .BLOCK_AW(BLOCK_AW)) u_base (
    .base_sel (base_sel),
    .base_ok  (base_ok),
    .base_blk (base_blk)
  );

  bw_region_match #(.ADDR_W(ADDR_W), .BLOCK_AW(BLOCK_AW), .ROM_AW(ROM_AW)) u_match (
    .addr     (addr),
    .mem_rd   (mem_rd),
    .base_ok  (base_ok),
    .base_blk (base_blk),
    .rom_cs   (rom_cs)
  );

  bw_pending_flag u_flag (
    .clk        (clk),
    .por_n      (por_n),
    .cpu_reset  (cpu_reset),
    .jump_en_n  (jump_en_n),
    .rom_cs     (rom_cs),
    .pending_q  (pending_q),
    .reset_rise (reset_rise)
  );

  assign src = pick_src(pending_q, rom_cs, blank_on_rom);

  always_comb begin
    case (src)
      SRC_ROM:  cpu_din = rom_dout;
      SRC_ZERO: cpu_din = '0;
      default:  cpu_din = bus_din;
    endcase
  end

  assign rcv_en = (src == SRC_BUS);

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (pending_q && !rom_cs) |-> (cpu_din == '0 && !rcv_en));           // R2
  AST_ROM_NEEDS_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    rom_cs |-> $onehot(base_sel));                                    // R5
  AST_ROM_NEEDS_READ: assert property (@(posedge clk) disable iff (!por_n)
    rom_cs |-> mem_rd);                                               // R7
  AST_ROM_DATA: assert property (@(posedge clk) disable iff (!por_n)
    (rom_cs && blank_on_rom) |-> (!rcv_en && cpu_din == rom_dout));   // R8
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!por_n)
    (!pending_q && !rom_cs) |-> (rcv_en && cpu_din == bus_din));      // R11

endmodule

// File: tb/boot_walk_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_walk_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        cpu_reset = 1'b0;
  logic        jump_en_n = 1'b1;
  logic [7:0]  base_sel = 8'h00;
  logic        blank_on_rom = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        mem_rd = 1'b0;
  logic [7:0]  bus_din = 8'h00;
  logic [7:0]  rom_dout = 8'hC3;
  logic [7:0]  cpu_din;
  logic        rcv_en;
  logic        rom_cs;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  boot_walk_ctrl dut_i (
    .clk          (clk),
    .por_n        (por_n),
    .cpu_reset    (cpu_reset),
    .jump_en_n    (jump_en_n),
    .base_sel     (base_sel),
    .blank_on_rom (blank_on_rom),
    .addr         (addr),
    .mem_rd       (mem_rd),
    .bus_din      (bus_din),
    .rom_dout     (rom_dout),
    .cpu_din      (cpu_din),
    .rcv_en       (rcv_en),
    .rom_cs       (rom_cs)
  );

  // {base_sel, addr, mem_rd, expected rom_cs}, flag clear, blank_on_rom = 1
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {8'h80, 16'h8000, 1'b1, 1'b1},   // R4 bit7 -> 0x8000
    {8'h80, 16'h83FF, 1'b1, 1'b1},   // R6 top of window
    {8'h80, 16'h8400, 1'b1, 1'b0},   // R6 just past window
    {8'h01, 16'hF000, 1'b1, 1'b1},   // R4 bit0 -> 0xF000
    {8'h01, 16'hF3FF, 1'b1, 1'b1},   // R6
    {8'h01, 16'hEFFF, 1'b1, 1'b0},   // R6 base-1
    {8'h10, 16'hB000, 1'b1, 1'b1},   // R4 bit4 -> 0xB000
    {8'h10, 16'hB000, 1'b0, 1'b0},   // R7 no memory read
    {8'h00, 16'h8000, 1'b1, 1'b0},   // R5 empty selector
    {8'h11, 16'hB000, 1'b1, 1'b0},   // R5 two-hot selector
    {8'h02, 16'hE200, 1'b1, 1'b1},   // R4 bit1 -> 0xE000
    {8'h04, 16'h0000, 1'b1, 1'b0},   // R11 plain read
    {8'h08, 16'hC3FF, 1'b1, 1'b1},   // R4 bit3 -> 0xC000
    {8'h40, 16'h9000, 1'b1, 1'b1}    // R4 bit6 -> 0x9000
  };

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Checks the data path outputs against expected read data and receiver state.
  task automatic chk_out(input string req, input logic [7:0] exp_din,
                         input logic exp_rcv, input logic exp_cs);
    #1;
    chk(cpu_din == exp_din, req, {8'h00, cpu_din}, {8'h00, exp_din});
    chk(rcv_en == exp_rcv, req, {15'h0, rcv_en}, {15'h0, exp_rcv});
    chk(rom_cs == exp_cs, req, {15'h0, rom_cs}, {15'h0, exp_cs});
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 5000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual %0d expected below 5000", cyc_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bus_din = 8'h77;
    #1;
    // R10 reset state: flag clear during power-on clear
    chk_out("R10 reset state", 8'h77, 1'b1, 1'b0);
    cyc(); cyc();
    por_n = 1'b1;
    cyc();

    // Decode table with the flag clear
    for (int i = 0; i < NV; i++) begin
      base_sel = VEC[i][25:18];
      addr     = VEC[i][17:2];
      mem_rd   = VEC[i][1];
      bus_din  = addr[7:0] ^ 8'h5A;
      chk_out($sformatf("decode vector %0d (R4 R5 R6 R7 R11)", i),
              VEC[i][0] ? rom_dout : bus_din, !VEC[i][0], VEC[i][0]);
      cyc();
    end

    // R10: power-on clear with reset held high arms on the first clock
    por_n = 1'b0; cpu_reset = 1'b1; jump_en_n = 1'b0;
    mem_rd = 1'b1; addr = 16'h0000; base_sel = 8'h08; bus_din = 8'hA5;
    chk_out("R10 async clear", 8'hA5, 1'b1, 1'b0);
    cyc();
    por_n = 1'b1;
    cyc();
    chk_out("R10 armed after power-on", 8'h00, 1'b0, 1'b0);
    cyc();
    cpu_reset = 1'b0;

    // R9: stopped at 0x0000, reads zero for many cycles
    for (int k = 0; k < 20; k++) begin
      bus_din = 8'(k * 13 + 1);
      chk_out("R9 held pending", 8'h00, 1'b0, 1'b0);
      cyc();
    end

    // R2: just below the region still blanked
    addr = 16'hBFFF; bus_din = 8'hFF;
    chk_out("R2 below base", 8'h00, 1'b0, 1'b0);
    cyc();
    // R3: the hit itself returns ROM data
    addr = 16'hC000;
    chk_out("R3 hit shows rom", rom_dout, 1'b0, 1'b1);
    cyc();
    addr = 16'h0010; bus_din = 8'h3E;
    chk_out("R3 cleared after hit", 8'h3E, 1'b1, 1'b0);
    cyc();

    // R1: reset edge with enable high leaves the flag clear
    jump_en_n = 1'b1; cpu_reset = 1'b1;
    cyc();
    cpu_reset = 1'b0; addr = 16'h0000; bus_din = 8'h42;
    chk_out("R1 not armed when disabled", 8'h42, 1'b1, 1'b0);
    cyc();

    // R1: reset edge with enable low arms
    jump_en_n = 1'b0; cpu_reset = 1'b1;
    cyc();
    cpu_reset = 1'b0; bus_din = 8'h99;
    chk_out("R1 armed on reset edge", 8'h00, 1'b0, 1'b0);
    cyc();

    // R7: I/O cycle at the base neither selects nor clears
    addr = 16'hC000; mem_rd = 1'b0;
    chk_out("R7 io at base", 8'h00, 1'b0, 1'b0);
    cyc();
    addr = 16'h0020; mem_rd = 1'b1;
    chk_out("R7 still pending", 8'h00, 1'b0, 1'b0);
    cyc();

    // R8: no ROM fitted, memory at the jump address visible
    blank_on_rom = 1'b0; addr = 16'hC100; bus_din = 8'h5C;
    chk_out("R8 no rom shows bus", 8'h5C, 1'b1, 1'b1);
    cyc();
    addr = 16'h0030; bus_din = 8'h61;
    chk_out("R8 then cleared", 8'h61, 1'b1, 1'b0);
    cyc();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule